// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the row and column strobes of an asynchronous DRAM during start-up and refresh. After reset it holds all strobes inactive for a programmable settling time. It then runs a fixed number of dummy refresh cycles without asking anyone, and raises `ready` once the last one has finished. From then on an interval timer produces one refresh token per interval. Each token becomes a CAS-before-RAS refresh once the access controller grants the strobes.

A refresh carries no row address because the memory steps its own internal row counter. The cycle is signalled by strobe order alone: both column strobes go low first, the row strobe follows, the column strobes are released while the row strobe is still low, and a precharge gap ends the cycle. Tokens that arrive while the grant is withheld are stored in a saturating counter. The access controller can therefore keep a page open for several intervals without losing a refresh. All timing is given as parameters in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `ras_n`, `ucas_n` and `lcas_n` are 1 (inactive) and `busy`, `ready` and `refresh_req` are 0.
- R2: After reset is released, the column strobes first fall exactly STARTUP_CYCLES clock cycles later. No strobe moves before then.
- R3: Exactly INIT_CYCLES refresh cycles run after the start-up wait, regardless of `refresh_gnt` and with `refresh_req` held low. `ready` rises as the last of them ends its precharge, and it then stays high until reset.
- R4: In every refresh cycle, `ucas_n` and `lcas_n` fall together and stay low for at least T_CSR cycles before `ras_n` falls.
- R5: After `ras_n` falls, the column strobes stay low for at least T_CHR cycles and rise while `ras_n` is still low.
- R6: `ras_n` stays low for at least T_RAS cycles per refresh. It is high for at least T_RP cycles before the column strobes fall again.
- R7: Once `ready` is high, one refresh token is produced every INTERVAL_CYCLES cycles. With `refresh_gnt` held at 1, successive `ras_n` falls are exactly INTERVAL_CYCLES cycles apart.
- R8: After `ready`, `refresh_req` is 1 only while idle with at least one stored token. A refresh starts only on a cycle in which `refresh_req` and `refresh_gnt` are both 1. While `refresh_gnt` is 0 the strobes do not move, and `refresh_req` is 0 whenever `busy` is 1.
- R9: Stored tokens saturate at PEND_MAX. After a denial covering more than PEND_MAX intervals, a grant yields exactly PEND_MAX back-to-back refreshes before `refresh_req` drops.
- R10: Below the limit no token is lost. k intervals without a grant lead to exactly k refreshes once the grant arrives.
- R11: `busy` is 1 whenever any strobe is low, and 0 while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| refresh_gnt | input | 1 | Access controller hands over the strobes |
| refresh_req | output | 1 | Sequencer asks for the strobes for a refresh |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| busy | output | 1 | A refresh or dummy cycle is driving the strobes |
| ready | output | 1 | Initialization finished; normal accesses allowed |

## Verification
The bench aims at the start-up count and the dummy-cycle count, because an off-by-one there either starts refresh before the settling time or raises `ready` one cycle short of initialization. It withholds the grant for more than eight intervals to show that the token counter saturates rather than wrapping to zero, which would silently drop a whole burst. A shorter denial shows that simultaneous token arrival and consumption neither loses nor duplicates a refresh. Strobe monitors measure every setup, hold, low and precharge window, so a phase counter that ends one cycle early is reported as a timing violation rather than passing as a refresh with the wrong order.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        ST_SETTLE  = 3'd0,
        ST_CAS_LEAD = 3'd1,
        ST_BOTH_LOW = 3'd2,
        ST_RAS_TAIL = 3'd3,
        ST_PRECHG  = 3'd4,
        ST_IDLE    = 3'd5
    } seq_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
    parameter int INTERVAL_CYCLES = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          tick_d, tick_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_d = 1'b0;
        if (run) begin
            if (cnt_q == '0) begin
                cnt_d  = CW'(INTERVAL_CYCLES - 1);
                tick_d = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= CW'(INTERVAL_CYCLES - 1);
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;

    generate
        if (INTERVAL_CYCLES > 1) begin : g_spacing
            a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
                tick_q |=> !tick_q);
        end
    endgenerate

endmodule

// File: rtl/refresh_pending_ctr.sv
module refresh_pending_ctr #(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nonzero
);
    localparam int PW = $clog2(PEND_MAX + 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec) begin
            if (cnt_q != PW'(PEND_MAX)) cnt_d = cnt_q + 1'b1;
        end else if (dec && !inc) begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign nonzero = (cnt_q != '0);

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PW'(PEND_MAX));

    a_r10_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    a_r10_keep_token: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt_q != PW'(PEND_MAX)) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
    import dram_refresh_pkg::*;
#(
    parameter int STARTUP_CYCLES = 20001,
    parameter int INIT_CYCLES    = 8,
    parameter int T_CSR          = 2,
    parameter int T_CHR          = 2,
    parameter int T_RAS          = 12,
    parameter int T_RP           = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nz,
    input  logic gnt,
    output logic start,
    output logic req,
    output logic ready,
    output logic ras_n,
    output logic cas_n,
    output logic busy
);
    localparam int MAX_LOAD = max_of(max_of(STARTUP_CYCLES, T_RAS), max_of(T_CSR, T_RP));
    localparam int CW       = $clog2(MAX_LOAD + 1);
    localparam int DW       = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
        logic [DW-1:0]  dummies;
        logic           ready;
        logic           ras_n;
        logic           cas_n;
        logic           busy;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    assign req   = r_q.ready && (r_q.st == ST_IDLE) && pend_nz;
    assign start = req && gnt;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_SETTLE: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_CAS_LEAD;
                    r_d.cnt = CW'(T_CSR - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_CAS_LEAD: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_BOTH_LOW;
                    r_d.cnt = CW'(T_CHR - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_BOTH_LOW: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_RAS_TAIL;
                    r_d.cnt = CW'(T_RAS - T_CHR - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RAS_TAIL: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_PRECHG;
                    r_d.cnt = CW'(T_RP - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_PRECHG: begin
                if (r_q.cnt == '0) begin
                    if (r_q.ready) begin
                        r_d.st = ST_IDLE;
                    end else if (r_q.dummies == DW'(INIT_CYCLES - 1)) begin
                        r_d.st    = ST_IDLE;
                        r_d.ready = 1'b1;
                    end else begin
                        r_d.dummies = r_q.dummies + 1'b1;
                        r_d.st      = ST_CAS_LEAD;
                        r_d.cnt     = CW'(T_CSR - 1);
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_IDLE: begin
                if (start) begin
                    r_d.st  = ST_CAS_LEAD;
                    r_d.cnt = CW'(T_CSR - 1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        r_d.ras_n = !(r_d.st == ST_BOTH_LOW || r_d.st == ST_RAS_TAIL);
        r_d.cas_n = !(r_d.st == ST_CAS_LEAD || r_d.st == ST_BOTH_LOW);
        r_d.busy  = (r_d.st != ST_IDLE) && (r_d.st != ST_SETTLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_SETTLE;
            r_q.cnt     <= CW'(STARTUP_CYCLES - 1);
            r_q.dummies <= '0;
            r_q.ready   <= 1'b0;
            r_q.ras_n   <= 1'b1;
            r_q.cas_n   <= 1'b1;
            r_q.busy    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready = r_q.ready;
    assign ras_n = r_q.ras_n;
    assign cas_n = r_q.cas_n;
    assign busy  = r_q.busy;

    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.ras_n) |-> (!r_q.cas_n && $past(!r_q.cas_n)));

    a_r5_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.cas_n) |-> !r_q.ras_n);

    a_r6_ras_high_at_cas_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.cas_n) |-> r_q.ras_n);

    a_r11_busy_covers_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.ras_n || !r_q.cas_n) |-> r_q.busy);

    a_r8_req_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |-> !req);

    a_r8_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(r_q.cas_n) && $past(r_q.ready)) |-> $past(gnt));

    a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ready |=> r_q.ready);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int STARTUP_CYCLES  = 20001,
    parameter int INIT_CYCLES     = 8,
    parameter int INTERVAL_CYCLES = 3125,
    parameter int PEND_MAX        = 8,
    parameter int T_CSR           = 2,
    parameter int T_CHR           = 2,
    parameter int T_RAS           = 12,
    parameter int T_RP            = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_gnt,
    output logic refresh_req,
    output logic ras_n,
    output logic ucas_n,
    output logic lcas_n,
    output logic busy,
    output logic ready
);
    logic tick, pend_nz, start, cas_n, ready_i;

    refresh_tick_gen #(
        .INTERVAL_CYCLES (INTERVAL_CYCLES)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ready_i),
        .tick  (tick)
    );

    refresh_pending_ctr #(
        .PEND_MAX (PEND_MAX)
    ) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tick),
        .dec     (start),
        .nonzero (pend_nz)
    );

    cbr_strobe_fsm #(
        .STARTUP_CYCLES (STARTUP_CYCLES),
        .INIT_CYCLES    (INIT_CYCLES),
        .T_CSR          (T_CSR),
        .T_CHR          (T_CHR),
        .T_RAS          (T_RAS),
        .T_RP           (T_RP)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_nz (pend_nz),
        .gnt     (refresh_gnt),
        .start   (start),
        .req     (refresh_req),
        .ready   (ready_i),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .busy    (busy)
    );

    assign ucas_n = cas_n;
    assign lcas_n = cas_n;
    assign ready  = ready_i;

endmodule

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;
    localparam int STARTUP  = 300;
    localparam int INIT     = 8;
    localparam int INTERVAL = 1000;
    localparam int PMAX     = 8;
    localparam int TCSR     = 2;
    localparam int TCHR     = 2;
    localparam int TRAS     = 12;
    localparam int TRP      = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic req, ras_n, ucas_n, lcas_n, busy, ready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dram_refresh_seq #(
        .STARTUP_CYCLES (STARTUP), .INIT_CYCLES (INIT), .INTERVAL_CYCLES (INTERVAL),
        .PEND_MAX (PMAX), .T_CSR (TCSR), .T_CHR (TCHR), .T_RAS (TRAS), .T_RP (TRP)
    ) i_dram_refresh_seq (
        .clk (clk), .rst_n (rst_n), .refresh_gnt (gnt), .refresh_req (req),
        .ras_n (ras_n), .ucas_n (ucas_n), .lcas_n (lcas_n), .busy (busy), .ready (ready)
    );

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // strobe monitor, sampled on the falling clock edge
    int  ras_falls = 0;
    int  cyc_ready = 0;
    int  cas_lead = 0, ras_low = 0, ras_high = 1000, cas_after = 0;
    bit  p_ras = 1'b1, p_cas = 1'b1, req_early = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_ras = 1'b1; p_cas = 1'b1; cas_lead = 0; ras_low = 0; ras_high = 1000;
            cyc_ready = 0;
        end else begin
            if (!ready && req) req_early = 1'b1;
            if (ready) cyc_ready++;
            if (p_cas && !ucas_n)
                check("R6 precharge before CAS", ras_high >= TRP, ras_high, TRP);
            if (p_ras && !ras_n) begin
                ras_falls++;
                check("R4 CAS lead before RAS", !ucas_n && !lcas_n && cas_lead >= TCSR, cas_lead, TCSR);
                check("R11 busy at RAS fall", busy == 1'b1, busy, 1);
                check("R8 req low while busy", req == 1'b0, req, 0);
                cas_after = 0;
            end
            if (!p_ras && ras_n)
                check("R6 RAS low width", ras_low >= TRAS, ras_low, TRAS);
            if (!p_cas && ucas_n && !p_ras)
                check("R5 CAS hold after RAS", cas_after >= TCHR && !ras_n, cas_after, TCHR);
            if (ucas_n != lcas_n) check("R4 strobe pair equal", 1'b0, lcas_n, ucas_n);
            cas_lead  = (!ucas_n && ras_n) ? cas_lead + 1 : 0;
            ras_low   = !ras_n ? ras_low + 1 : 0;
            ras_high  = ras_n ? ras_high + 1 : 0;
            if (!ras_n && !ucas_n) cas_after++;
            p_ras = ras_n; p_cas = ucas_n;
        end
    end

    task automatic t_reset_state();
        rst_n = 1'b0; gnt = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 ras_n in reset", ras_n == 1'b1, ras_n, 1);
        check("R1 cas in reset", ucas_n == 1'b1 && lcas_n == 1'b1, ucas_n, 1);
        check("R1 flags in reset", {busy, ready, req} == 3'b000, {busy, ready, req}, 0);
    endtask

    task automatic t_startup_and_init();
        int n = 0;
        int f0;
        rst_n = 1'b1;
        @(negedge clk);
        n = 1;
        check("R1 inactive after release", ras_n && ucas_n && !busy, ras_n, 1);
        while (ucas_n) begin @(negedge clk); n++; end
        check("R2 start-up wait length", n == STARTUP, n, STARTUP);
        f0 = ras_falls;
        while (!ready) @(negedge clk);
        check("R3 dummy cycle count", ras_falls - f0 == INIT, ras_falls - f0, INIT);
        check("R3 no request during init", req_early == 1'b0, req_early, 0);
        check("R11 idle after init", busy == 1'b0 && ras_n && ucas_n, busy, 0);
    endtask

    task automatic t_saturate();
        int f0;
        while (cyc_ready < 10 * INTERVAL + 300) @(negedge clk);
        check("R8 no strobe without grant", ras_falls == 8, ras_falls, 8);
        check("R8 request pending", req == 1'b1, req, 1);
        check("R3 ready stays high", ready == 1'b1, ready, 1);
        f0 = ras_falls;
        gnt = 1'b1;
        @(negedge clk);
        while (req || busy) @(negedge clk);
        check("R9 saturated burst", ras_falls - f0 == PMAX, ras_falls - f0, PMAX);
        gnt = 1'b0;
    endtask

    task automatic t_no_loss();
        int f0 = ras_falls;
        while (cyc_ready < 13 * INTERVAL + 500) @(negedge clk);
        check("R8 no strobe during denial", ras_falls == f0, ras_falls - f0, 0);
        gnt = 1'b1;
        @(negedge clk);
        while (req || busy) @(negedge clk);
        check("R10 tokens kept", ras_falls - f0 == 3, ras_falls - f0, 3);
        check("R11 busy low when idle", busy == 1'b0, busy, 0);
    endtask

    task automatic t_interval();
        int t_prev, f0;
        f0 = ras_falls;
        while (ras_falls == f0) @(negedge clk);
        t_prev = cyc_ready;
        for (int k = 0; k < 3; k++) begin
            f0 = ras_falls;
            while (ras_falls == f0) @(negedge clk);
            check("R7 refresh spacing", cyc_ready - t_prev == INTERVAL, cyc_ready - t_prev, INTERVAL);
            t_prev = cyc_ready;
        end
    endtask

    task automatic t_reset_midcycle();
        while (!busy) @(negedge clk);
        repeat (TCSR + 1) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset mid refresh", ras_n && ucas_n && lcas_n && !busy && !ready && !req,
              {ras_n, ucas_n, lcas_n}, 7);
        @(negedge clk);
    endtask

    initial begin
        t_reset_state();
        t_startup_and_init();
        t_saturate();
        t_no_loss();
        t_interval();
        t_reset_midcycle();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule